// File: doc/BRIEF.md
# Watchdog Supervisor with Safe-Frequency Fallback

This block watches over the frequency-select code that a clock generator uses. Software loads a timeout in units of a slow prescaled tick. While the watchdog is enabled, the block counts ticks down from that value. If software does not service it in time, the block raises a sticky alarm. It then replaces the active frequency code with a stored safe code and drives an active-low system reset pulse.

The safe code comes from one of two places, chosen by a mode bit: the frequency straps latched at power-up, or a programmed 5-bit field. Outside an alarm, the active code is either the latched strap code or a code that software has programmed. Any change of the active code also produces the reset pulse, so the system restarts cleanly on the new frequency.

Software reaches the block through four write strobes that share one data byte. The enable comes from a latched strap until the first control write. After that, the register bit decides.

Top module: `wdt_safe_freq`

## Requirements
- R1: After reset the timeout is 8 ticks, the safe code field is 01000, the safe-code source is the straps, the alarm is 0, `sys_rst_no` is 1 and `act_fs_o` equals `strap_fs_i`.
- R2: Until the first control write the watchdog is enabled by `strap_wden_i`. From the first control write (`wr_ctrl_i`) onward, data bit 7 of the latest control write enables it (1) or disables it (0), whatever the strap says.
- R3: With timeout X, an enabled watchdog that is not in alarm expires on the X-th tick after its last reload. When X is 0 it expires on the first tick.
- R4: A service pulse (`svc_i`) reloads the counter to X. A service pulse and a tick in the same cycle count as a service only.
- R5: On expiry the alarm is set on the same clock edge. The alarm then stays set, and the counter is frozen, until a control write with data bit 6 = 0. A control write with bit 6 = 1 leaves the alarm alone. Every control write and every timeout write (`wr_tmo_i`, data bits 7:0) reloads the counter.
- R6: While the alarm is set, `act_fs_o` is the safe code. The safe code is `strap_fs_i` when control bit 5 is 0, and the safe field (`wr_safe_i`, data bits 4:0) when it is 1.
- R7: `sys_rst_no` is low for exactly RST_CYC (default 4) cycles after the clock edge of an expiry or of any change of `act_fs_o`. An edge that leaves the code unchanged and is not an expiry gives no pulse.
- R8: While the watchdog is disabled, ticks never raise the alarm.
- R9: A frequency write (`wr_freq_i`) sets the programmed code from data bits 4:0 and the use flag from bit 5. Outside an alarm, `act_fs_o` is the programmed code when the flag is 1 and `strap_fs_i` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled timebase tick, one cycle wide |
| svc_i | input | 1 | Watchdog service pulse |
| strap_wden_i | input | 1 | Latched hardware watchdog enable strap |
| strap_fs_i | input | 5 | Latched hardware frequency code |
| wr_tmo_i | input | 1 | Timeout register write strobe |
| wr_ctrl_i | input | 1 | Control write strobe (enable, keep-alarm, source) |
| wr_safe_i | input | 1 | Safe code field write strobe |
| wr_freq_i | input | 1 | Programmed frequency write strobe |
| wr_data_i | input | 8 | Shared write data byte |
| act_fs_o | output | 5 | Active frequency code |
| alarm_o | output | 1 | Watchdog alarm status |
| sys_rst_no | output | 1 | Active-low system reset pulse |

## Verification
The countdown is swept over timeouts 0 through 12 and 255. Each run counts the ticks up to the alarm, so an off-by-one in the reload or the expiry test is caught, along with the special case of zero. Service pulses are placed alone and together with a tick, which tells a reload apart from a decrement. Enable is tried from the strap and from the register in both polarities.

All 32 safe codes are written while in alarm, with the same code repeated once. Because each write is followed by a measurement of the reset pulse width, this separates real code changes from unchanged writes. The strap and programmed fallback sources are exercised, and the alarm is cleared to show the counter reload.

// File: rtl/wdt_sf_pkg.sv
`timescale 1ns/1ps
package wdt_sf_pkg;
  // shared write data byte
  localparam int REG_W = 8;
  // control write fields
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_KEEP_BIT = 6;
  localparam int CTL_SRC_BIT  = 5;
  // frequency write field
  localparam int FRQ_USE_BIT  = 5;
  // default code width of the frequency selector
  localparam int FS_W = 5;
endpackage

// File: rtl/wdt_sf_codesel.sv
`timescale 1ns/1ps
module wdt_sf_codesel #(
  parameter int CODE_W = 5
) (
  input  logic              alarm_i,
  input  logic              src_prog_i,
  input  logic [CODE_W-1:0] safe_i,
  input  logic              use_prog_i,
  input  logic [CODE_W-1:0] prog_i,
  input  logic [CODE_W-1:0] strap_i,
  output logic [CODE_W-1:0] code_o
);
  function automatic logic [CODE_W-1:0] pick_code(
    input logic alarm, input logic src_prog, input logic [CODE_W-1:0] safe,
    input logic use_prog, input logic [CODE_W-1:0] prog, input logic [CODE_W-1:0] strap);
    logic [CODE_W-1:0] fallback;
    logic [CODE_W-1:0] normal;
    fallback = src_prog ? safe : strap;
    normal   = use_prog ? prog : strap;
    return alarm ? fallback : normal;
  endfunction

  always_comb code_o = pick_code(alarm_i, src_prog_i, safe_i, use_prog_i, prog_i, strap_i);
endmodule

// File: rtl/wdt_sf_regs.sv
`timescale 1ns/1ps
module wdt_sf_regs
  import wdt_sf_pkg::*;
#(
  parameter int                TMO_W    = 8,
  parameter int                CODE_W   = 5,
  parameter logic [TMO_W-1:0]  DEF_TMO  = 8,
  parameter logic [CODE_W-1:0] DEF_SAFE = 5'b01000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_wden_i,
  input  logic              wr_tmo_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_safe_i,
  input  logic              wr_freq_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              expire_i,
  output logic [TMO_W-1:0]  tmo_d_o,
  output logic              en_o,
  output logic              alarm_q_o,
  output logic              alarm_d_o,
  output logic              src_q_o,
  output logic              src_d_o,
  output logic [CODE_W-1:0] safe_q_o,
  output logic [CODE_W-1:0] safe_d_o,
  output logic              use_q_o,
  output logic              use_d_o,
  output logic [CODE_W-1:0] prog_q_o,
  output logic [CODE_W-1:0] prog_d_o
);
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic              en_q, en_d, ovr_q, ovr_d;
  logic              alarm_q, alarm_d, src_q, src_d, use_q, use_d;
  logic [CODE_W-1:0] safe_q, safe_d, prog_q, prog_d;
  logic              ctl_clear;

  assign ctl_clear = wr_ctrl_i && !wr_data_i[CTL_KEEP_BIT];

  always_comb begin
    tmo_d   = tmo_q;
    en_d    = en_q;
    ovr_d   = ovr_q;
    src_d   = src_q;
    safe_d  = safe_q;
    use_d   = use_q;
    prog_d  = prog_q;
    alarm_d = alarm_q;
    if (wr_tmo_i) tmo_d = wr_data_i[TMO_W-1:0];
    if (wr_ctrl_i) begin
      en_d  = wr_data_i[CTL_EN_BIT];
      ovr_d = 1'b1;
      src_d = wr_data_i[CTL_SRC_BIT];
    end
    if (ctl_clear) alarm_d = 1'b0;
    if (expire_i)  alarm_d = 1'b1;
    if (wr_safe_i) safe_d = wr_data_i[CODE_W-1:0];
    if (wr_freq_i) begin
      use_d  = wr_data_i[FRQ_USE_BIT];
      prog_d = wr_data_i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q   <= DEF_TMO;
      en_q    <= 1'b0;
      ovr_q   <= 1'b0;
      src_q   <= 1'b0;
      safe_q  <= DEF_SAFE;
      use_q   <= 1'b0;
      prog_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      tmo_q   <= tmo_d;
      en_q    <= en_d;
      ovr_q   <= ovr_d;
      src_q   <= src_d;
      safe_q  <= safe_d;
      use_q   <= use_d;
      prog_q  <= prog_d;
      alarm_q <= alarm_d;
    end
  end

  assign tmo_d_o   = tmo_d;
  assign en_o      = ovr_q ? en_q : strap_wden_i;
  assign alarm_q_o = alarm_q;
  assign alarm_d_o = alarm_d;
  assign src_q_o   = src_q;
  assign src_d_o   = src_d;
  assign safe_q_o  = safe_q;
  assign safe_d_o  = safe_d;
  assign use_q_o   = use_q;
  assign use_d_o   = use_d;
  assign prog_q_o  = prog_q;
  assign prog_d_o  = prog_d;

  AST_ALARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> alarm_q); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !(wr_ctrl_i && !wr_data_i[CTL_KEEP_BIT])) |=> alarm_q); // R5
  AST_ALARM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && !wr_data_i[CTL_KEEP_BIT] && !expire_i) |=> !alarm_q); // R5
endmodule

// File: rtl/wdt_sf_timer.sv
`timescale 1ns/1ps
module wdt_sf_timer #(
  parameter int               TMO_W   = 8,
  parameter logic [TMO_W-1:0] DEF_TMO = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             svc_i,
  input  logic             en_i,
  input  logic             alarm_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             hold_load;
  logic             last_unit;

  // X=0 and X=1 both end on the next tick
  function automatic logic is_last(input logic [TMO_W-1:0] c);
    return c <= TMO_W'(1);
  endfunction

  assign hold_load = !en_i || reload_i || svc_i;
  assign last_unit = is_last(cnt_q);
  assign expire_o  = en_i && !alarm_i && tick_i && !reload_i && !svc_i && last_unit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= DEF_TMO;
    else if (hold_load)                      cnt_q <= load_val_i;
    else if (tick_i && !alarm_i && !last_unit) cnt_q <= cnt_q - TMO_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !alarm_i && tick_i && !svc_i && !reload_i && cnt_q > TMO_W'(1))
      |=> cnt_q == $past(cnt_q) - TMO_W'(1)); // R3
  AST_FROZEN_IN_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i && en_i && !svc_i && !reload_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdt_sf_pulse.sv
`timescale 1ns/1ps
module wdt_sf_pulse #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rst_no
);
  localparam int PW_W = $clog2(RST_CYC + 1);
  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            out_q;

  always_comb begin
    if (trig_i)                cnt_d = PW_W'(RST_CYC);
    else if (cnt_q != '0)      cnt_d = cnt_q - PW_W'(1);
    else                       cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= (cnt_d == '0);
    end
  end

  assign rst_no = out_q;

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !rst_no); // R7
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == PW_W'(1) && !trig_i) |=> rst_no); // R7
endmodule

// File: rtl/wdt_safe_freq.sv
`timescale 1ns/1ps
module wdt_safe_freq
  import wdt_sf_pkg::*;
#(
  parameter int                TMO_W    = 8,
  parameter int                CODE_W   = FS_W,
  parameter logic [TMO_W-1:0]  DEF_TMO  = 8,
  parameter logic [CODE_W-1:0] DEF_SAFE = 5'b01000,
  parameter int                RST_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              svc_i,
  input  logic              strap_wden_i,
  input  logic [CODE_W-1:0] strap_fs_i,
  input  logic              wr_tmo_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_safe_i,
  input  logic              wr_freq_i,
  input  logic [7:0]        wr_data_i,
  output logic [CODE_W-1:0] act_fs_o,
  output logic              alarm_o,
  output logic              sys_rst_no
);
  logic [TMO_W-1:0]  tmo_d;
  logic              wd_en, alarm_q, alarm_d, src_q, src_d, use_q, use_d;
  logic [CODE_W-1:0] safe_q, safe_d, prog_q, prog_d;
  logic [CODE_W-1:0] code_now, code_next;
  logic              expire, code_moves, pulse_trig;

  wdt_sf_regs #(.TMO_W(TMO_W), .CODE_W(CODE_W), .DEF_TMO(DEF_TMO), .DEF_SAFE(DEF_SAFE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_wden_i(strap_wden_i),
    .wr_tmo_i(wr_tmo_i), .wr_ctrl_i(wr_ctrl_i), .wr_safe_i(wr_safe_i), .wr_freq_i(wr_freq_i),
    .wr_data_i(wr_data_i), .expire_i(expire),
    .tmo_d_o(tmo_d), .en_o(wd_en), .alarm_q_o(alarm_q), .alarm_d_o(alarm_d),
    .src_q_o(src_q), .src_d_o(src_d), .safe_q_o(safe_q), .safe_d_o(safe_d),
    .use_q_o(use_q), .use_d_o(use_d), .prog_q_o(prog_q), .prog_d_o(prog_d)
  );

  wdt_sf_timer #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .svc_i(svc_i),
    .en_i(wd_en), .alarm_i(alarm_q), .reload_i(wr_tmo_i || wr_ctrl_i),
    .load_val_i(tmo_d), .expire_o(expire)
  );

  // current code from present state, next code from the state being loaded
  wdt_sf_codesel #(.CODE_W(CODE_W)) u_sel_now (
    .alarm_i(alarm_q), .src_prog_i(src_q), .safe_i(safe_q),
    .use_prog_i(use_q), .prog_i(prog_q), .strap_i(strap_fs_i), .code_o(code_now)
  );
  wdt_sf_codesel #(.CODE_W(CODE_W)) u_sel_next (
    .alarm_i(alarm_d), .src_prog_i(src_d), .safe_i(safe_d),
    .use_prog_i(use_d), .prog_i(prog_d), .strap_i(strap_fs_i), .code_o(code_next)
  );

  assign code_moves = (code_next != code_now);
  assign pulse_trig = expire || code_moves;

  wdt_sf_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(pulse_trig), .rst_no(sys_rst_no)
  );

  assign act_fs_o = code_now;
  assign alarm_o  = alarm_q;

  AST_SAFE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && src_q) |-> act_fs_o == safe_q); // R6
  AST_STRAP_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !src_q) |-> act_fs_o == strap_fs_i); // R6
  AST_OFF_NO_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wd_en && !alarm_o) |=> !alarm_o); // R8
  AST_EXPIRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> !sys_rst_no); // R7
endmodule

// File: tb/wdt_safe_freq_test.sv
`timescale 1ns/1ps
module wdt_safe_freq_test;
  localparam int RST_CYC = 4;

  logic       clk = 1'b0;
  logic       rst_n, tick, svc, s_wden;
  logic [4:0] s_fs;
  logic       w_tmo, w_ctl, w_safe, w_frq;
  logic [7:0] wdata;
  logic [4:0] act;
  logic       alarm, srst_n;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wdt_safe_freq #(.RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .svc_i(svc),
    .strap_wden_i(s_wden), .strap_fs_i(s_fs),
    .wr_tmo_i(w_tmo), .wr_ctrl_i(w_ctl), .wr_safe_i(w_safe), .wr_freq_i(w_frq),
    .wr_data_i(wdata), .act_fs_o(act), .alarm_o(alarm), .sys_rst_no(srst_n)
  );

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, a, e);
    end
  endtask

  task automatic do_reset(input logic wden, input logic [4:0] fs);
    rst_n = 1'b0; tick = 0; svc = 0; w_tmo = 0; w_ctl = 0; w_safe = 0; w_frq = 0; wdata = '0;
    s_wden = wden; s_fs = fs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 timeout, 1 control, 2 safe, 3 frequency
  task automatic wr(input int kind, input logic [7:0] d);
    wdata = d;
    w_tmo = (kind == 0); w_ctl = (kind == 1); w_safe = (kind == 2); w_frq = (kind == 3);
    @(negedge clk);
    w_tmo = 0; w_ctl = 0; w_safe = 0; w_frq = 0;
  endtask

  task automatic tick1();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic ticks_to_alarm(output int k);
    k = 0;
    for (int i = 1; i <= 300; i++) begin
      tick1();
      if (alarm) begin k = i; break; end
    end
  endtask

  task automatic pulse_len(output int w);
    w = 0;
    while (!srst_n && w < 100) begin w++; @(negedge clk); end
  endtask

  function automatic int exp_ticks(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic sweep_one(input int x);
    int k, w;
    logic [4:0] sc;
    sc = 5'((x * 5 + 1) % 32);
    do_reset(1'b0, 5'd7);
    wr(0, 8'(x));
    wr(2, {3'b000, sc});
    wr(1, 8'hE0);
    ticks_to_alarm(k);
    chk(k == exp_ticks(x), "R3 ticks to expiry", k, exp_ticks(x));
    chk(act == sc, "R6 safe field after expiry", act, sc);
    pulse_len(w);
    chk(w == RST_CYC, "R7 expiry pulse width", w, RST_CYC);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k, w;
    logic [4:0] prev;
    // R1 reset state, default timeout, strap enable
    do_reset(1'b1, 5'd19);
    chk(alarm == 1'b0, "R1 alarm after reset", alarm, 0);
    chk(srst_n == 1'b1, "R1 reset output idle", srst_n, 1);
    chk(act == 5'd19, "R1 active code is strap", act, 19);
    ticks_to_alarm(k);
    chk(k == 8, "R1 R2 default timeout with strap enable", k, 8);
    chk(act == 5'd19, "R6 strap fallback", act, 19);
    pulse_len(w);
    chk(w == RST_CYC, "R7 pulse with unchanged code", w, RST_CYC);

    // R1 default safe field
    do_reset(1'b1, 5'd3);
    wr(1, 8'hE0);
    ticks_to_alarm(k);
    chk(k == 8, "R1 default timeout", k, 8);
    chk(act == 5'b01000, "R1 default safe field", act, 8);

    // R2 R8 strap off, then register enables
    do_reset(1'b0, 5'd3);
    ticks(20);
    chk(alarm == 1'b0, "R8 strap disabled no alarm", alarm, 0);
    wr(1, 8'hC0);
    ticks_to_alarm(k);
    chk(k == 8, "R2 register enable", k, 8);

    // R2 register disables over strap
    do_reset(1'b1, 5'd3);
    wr(1, 8'h40);
    ticks(20);
    chk(alarm == 1'b0, "R2 R8 register disable overrides strap", alarm, 0);

    // R3 sweep of timeouts
    for (int x = 0; x <= 12; x++) sweep_one(x);
    sweep_one(255);

    // R4 service reload
    do_reset(1'b0, 5'd7);
    wr(0, 8'd5); wr(1, 8'hC0);
    ticks(4);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    ticks(4);
    chk(alarm == 1'b0, "R4 serviced no alarm", alarm, 0);
    tick1();
    chk(alarm == 1'b1, "R4 expiry after service", alarm, 1);

    // R4 service wins over simultaneous tick
    do_reset(1'b0, 5'd7);
    wr(0, 8'd3); wr(1, 8'hC0);
    ticks(2);
    svc = 1'b1; tick = 1'b1; @(negedge clk); svc = 1'b0; tick = 1'b0;
    ticks(2);
    chk(alarm == 1'b0, "R4 service with tick", alarm, 0);
    tick1();
    chk(alarm == 1'b1, "R4 full reload after service", alarm, 1);

    // R5 sticky alarm and clear
    wr(1, 8'hC0);
    chk(alarm == 1'b1, "R5 keep bit holds alarm", alarm, 1);
    ticks(30);
    chk(alarm == 1'b1, "R5 alarm sticky", alarm, 1);
    wr(3, 8'h2C);
    chk(act == 5'd7, "R6 alarm masks programmed code", act, 7);
    chk(srst_n == 1'b1, "R7 no pulse without code change", srst_n, 1);
    wr(1, 8'h80);
    chk(alarm == 1'b0, "R5 alarm cleared", alarm, 0);
    chk(act == 5'd12, "R9 programmed code after clear", act, 12);
    pulse_len(w);
    chk(w == RST_CYC, "R7 pulse on code change", w, RST_CYC);
    ticks_to_alarm(k);
    chk(k == 3, "R5 counter reloaded by clear", k, 3);
    wr(1, 8'h80);
    wr(3, 8'h0C);
    chk(act == 5'd7, "R9 use flag off selects strap", act, 7);

    // R9 R7 programmed code, repeat write, strap fallback
    do_reset(1'b0, 5'd9);
    wr(3, 8'h31);
    chk(act == 5'd17, "R9 programmed code", act, 17);
    pulse_len(w);
    chk(w == RST_CYC, "R7 pulse on program", w, RST_CYC);
    wr(3, 8'h31);
    chk(srst_n == 1'b1, "R7 same code no pulse", srst_n, 1);
    wr(0, 8'd2); wr(1, 8'hC0);
    ticks_to_alarm(k);
    chk(k == 2, "R3 timeout 2", k, 2);
    chk(act == 5'd9, "R6 strap source in alarm", act, 9);

    // R6 every safe code in alarm with programmed source
    wr(1, 8'hE0);
    chk(act == 5'b01000, "R6 source switch to field", act, 8);
    pulse_len(w);
    prev = 5'b01000;
    for (int c = 0; c < 32; c++) begin
      wr(2, 8'(c));
      chk(act == 5'(c), "R6 safe code sweep", act, c);
      pulse_len(w);
      chk(w == ((5'(c) != prev) ? RST_CYC : 0), "R7 pulse per safe write", w,
          (5'(c) != prev) ? RST_CYC : 0);
      prev = 5'(c);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule